// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block is a small, fully associative cache that maps virtual page numbers to physical frame numbers. Every entry carries an address-space identifier (ASID). Translations from several processes can therefore stay resident together, and each one only ever matches requests made under its own ASID. A lookup compares the requested page and the current ASID against all entries in parallel. The result appears on registered outputs one cycle later, either as a hit with the frame number or as a miss.

On a miss, an external page-table walker fetches the translation and presents it on the fill port. The block places the fill in the lowest-numbered free entry. When every entry is in use, it evicts the entry named by a round-robin pointer instead. A fill for a page and ASID that are already resident rewrites that entry, so no duplicate is ever created. Two kinds of invalidation are provided: one clears every entry, the other clears only the entries of one ASID.

Top module: `asid_tlb`

## Requirements
- R1: The cycle after `lookup_valid_i` is high, `hit_o` is 1 and `frame_o` holds the stored frame if a valid entry has both a page equal to `lookup_page_i` and an ASID equal to `lookup_asid_i`.
- R2: The cycle after a lookup with no such entry, `miss_o` is 1 and `frame_o` is 0. `hit_o` and `miss_o` are never high together, and both are 0 the cycle after a cycle with no lookup.
- R3: An entry whose page matches but whose ASID differs from the lookup ASID gives a miss. Entries holding the same page under different ASIDs are independent of each other.
- R4: An accepted fill writes the lowest-indexed invalid entry. When all entries are valid, it replaces the entry named by a round-robin pointer. The pointer starts at entry 0 after reset and advances by one, wrapping around, on each such replacement.
- R5: A fill whose page and ASID are already resident overwrites that entry's frame. It takes no new entry and does not move the round-robin pointer.
- R6: `flush_all_i` invalidates every entry in a single cycle.
- R7: `flush_asid_i` (with `flush_all_i` low) invalidates exactly the entries whose ASID equals `flush_asid_id_i`, and leaves all other entries intact.
- R8: A lookup made in the same cycle as a fill is answered from the contents as they were before that fill.
- R9: In a cycle with either flush request high, any fill is discarded. A lookup made in that same cycle is answered from the contents as they were before the flush.
- R10: After `rst_ni` is asserted, every entry is invalid and both `hit_o` and `miss_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lookup_valid_i | input | 1 | Translation request this cycle |
| lookup_asid_i | input | 4 | ASID of the requesting process |
| lookup_page_i | input | 4 | Virtual page to translate |
| fill_valid_i | input | 1 | Install a translation this cycle |
| fill_asid_i | input | 4 | ASID of the installed translation |
| fill_page_i | input | 4 | Page of the installed translation |
| fill_frame_i | input | 4 | Frame of the installed translation |
| flush_all_i | input | 1 | Invalidate all entries |
| flush_asid_i | input | 1 | Invalidate the entries of one ASID |
| flush_asid_id_i | input | 4 | ASID selected for invalidation |
| hit_o | output | 1 | Previous-cycle lookup hit |
| miss_o | output | 1 | Previous-cycle lookup missed |
| frame_o | output | 4 | Translated frame on a hit, else 0 |

## Verification
Two functions can land in the same cycle: a lookup together with a fill, and a lookup together with a flush, where the flush may also have a fill pending beside it. The bench provokes each case by driving the request and the update on the same falling edge. A reference model in the bench predicts the lookup answer from its entry state before it applies the update. The monitor then compares that prediction with the registered answer one cycle later, and further lookups show whether the update took effect or was discarded.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    FL_NONE = 2'd0,
    FL_ALL  = 2'd1,
    FL_ASID = 2'd2
  } flush_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N  = 8,
  parameter int AW = 4,
  parameter int PW = 4
) (
  input  logic [N-1:0]         valid_i,
  input  logic [N-1:0][AW-1:0] ent_asid_i,
  input  logic [N-1:0][PW-1:0] ent_page_i,
  input  logic [AW-1:0]        asid_i,
  input  logic [PW-1:0]        page_i,
  output logic [N-1:0]         match_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (ent_asid_i[g] == asid_i) && (ent_page_i[g] == page_i);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  valid_i,
  input  logic          replace_i,
  output logic [IW-1:0] idx_o,
  output logic          full_o
);
  logic [IW-1:0] rr_q;
  logic [IW-1:0] free_idx;
  logic          free_found;

  always_comb begin
    free_idx   = '0;
    free_found = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_idx   = IW'(i);
        free_found = 1'b1;
      end
    end
  end

  assign full_o = !free_found;
  assign idx_o  = free_found ? free_idx : rr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (replace_i) begin
      rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  AST_RR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(rr_q) < N); // R4
  AST_REPLACE_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    replace_i |-> full_o); // R4
endmodule

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int N  = 8,
  parameter int AW = 4,
  parameter int PW = 4,
  parameter int FW = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  flush_e               flush_op_i,
  input  logic [AW-1:0]        flush_asid_i,
  input  logic                 wr_en_i,
  input  logic [IW-1:0]        wr_idx_i,
  input  logic [AW-1:0]        wr_asid_i,
  input  logic [PW-1:0]        wr_page_i,
  input  logic [FW-1:0]        wr_frame_i,
  output logic [N-1:0]         valid_o,
  output logic [N-1:0][AW-1:0] asid_o,
  output logic [N-1:0][PW-1:0] page_o,
  output logic [N-1:0][FW-1:0] frame_o
);
  logic [N-1:0]         valid_q;
  logic [N-1:0][AW-1:0] asid_q;
  logic [N-1:0][PW-1:0] page_q;
  logic [N-1:0][FW-1:0] frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      asid_q  <= '0;
      page_q  <= '0;
      frame_q <= '0;
    end else begin
      unique case (flush_op_i)
        FL_ALL:  valid_q <= '0;
        FL_ASID: begin
          for (int i = 0; i < N; i++) begin
            if (asid_q[i] == flush_asid_i) valid_q[i] <= 1'b0;
          end
        end
        default: begin
          if (wr_en_i) begin
            valid_q[wr_idx_i] <= 1'b1;
            asid_q[wr_idx_i]  <= wr_asid_i;
            page_q[wr_idx_i]  <= wr_page_i;
            frame_q[wr_idx_i] <= wr_frame_i;
          end
        end
      endcase
    end
  end

  assign valid_o = valid_q;
  assign asid_o  = asid_q;
  assign page_o  = page_q;
  assign frame_o = frame_q;

  AST_FLUSH_ALL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_op_i == FL_ALL |=> valid_q == '0); // R6
  AST_FILL_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && flush_op_i == FL_NONE) |=> valid_q[$past(wr_idx_i)]); // R4

  for (genvar g = 0; g < N; g++) begin : g_chk
    AST_FLUSH_ASID_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flush_op_i == FL_ASID && asid_q[g] == flush_asid_i) |=> !valid_q[g]); // R7
    AST_FLUSH_ASID_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flush_op_i == FL_ASID && valid_q[g] && asid_q[g] != flush_asid_i) |=> valid_q[g]); // R7
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ASID_W  = 4,
  parameter int PAGE_W  = 4,
  parameter int FRAME_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lookup_valid_i,
  input  logic [ASID_W-1:0]  lookup_asid_i,
  input  logic [PAGE_W-1:0]  lookup_page_i,
  input  logic               fill_valid_i,
  input  logic [ASID_W-1:0]  fill_asid_i,
  input  logic [PAGE_W-1:0]  fill_page_i,
  input  logic [FRAME_W-1:0] fill_frame_i,
  input  logic               flush_all_i,
  input  logic               flush_asid_i,
  input  logic [ASID_W-1:0]  flush_asid_id_i,
  output logic               hit_o,
  output logic               miss_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]              ent_valid;
  logic [ENTRIES-1:0][ASID_W-1:0]  ent_asid;
  logic [ENTRIES-1:0][PAGE_W-1:0]  ent_page;
  logic [ENTRIES-1:0][FRAME_W-1:0] ent_frame;
  logic [ENTRIES-1:0]              lk_match;
  logic [ENTRIES-1:0]              fl_match;
  logic [FRAME_W-1:0]              lk_frame;
  logic [IW-1:0]                   dup_idx;
  logic [IW-1:0]                   vic_idx;
  logic [IW-1:0]                   wr_idx;
  logic                            full;
  logic                            fill_acc;
  logic                            replace;
  flush_e                          flush_op;
  logic                            hit_q;
  logic                            miss_q;
  logic [FRAME_W-1:0]              frame_q;

  assign flush_op = flush_all_i  ? FL_ALL  :
                    flush_asid_i ? FL_ASID : FL_NONE;
  assign fill_acc = fill_valid_i && (flush_op == FL_NONE);

  tlb_match #(.N(ENTRIES), .AW(ASID_W), .PW(PAGE_W)) u_lk_match (
    .valid_i    (ent_valid),
    .ent_asid_i (ent_asid),
    .ent_page_i (ent_page),
    .asid_i     (lookup_asid_i),
    .page_i     (lookup_page_i),
    .match_o    (lk_match)
  );

  tlb_match #(.N(ENTRIES), .AW(ASID_W), .PW(PAGE_W)) u_fl_match (
    .valid_i    (ent_valid),
    .ent_asid_i (ent_asid),
    .ent_page_i (ent_page),
    .asid_i     (fill_asid_i),
    .page_i     (fill_page_i),
    .match_o    (fl_match)
  );

  // match vectors are one-hot or empty, so OR-reduction selects
  always_comb begin
    lk_frame = '0;
    dup_idx  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) lk_frame = lk_frame | ent_frame[i];
      if (fl_match[i]) dup_idx  = dup_idx | IW'(i);
    end
  end

  assign replace = fill_acc && !(|fl_match) && full;
  assign wr_idx  = (|fl_match) ? dup_idx : vic_idx;

  tlb_victim #(.N(ENTRIES)) u_victim (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (ent_valid),
    .replace_i (replace),
    .idx_o     (vic_idx),
    .full_o    (full)
  );

  tlb_store #(.N(ENTRIES), .AW(ASID_W), .PW(PAGE_W), .FW(FRAME_W)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_op_i   (flush_op),
    .flush_asid_i (flush_asid_id_i),
    .wr_en_i      (fill_acc),
    .wr_idx_i     (wr_idx),
    .wr_asid_i    (fill_asid_i),
    .wr_page_i    (fill_page_i),
    .wr_frame_i   (fill_frame_i),
    .valid_o      (ent_valid),
    .asid_o       (ent_asid),
    .page_o       (ent_page),
    .frame_o      (ent_frame)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q   <= 1'b0;
      miss_q  <= 1'b0;
      frame_q <= '0;
    end else begin
      hit_q   <= lookup_valid_i && (|lk_match);
      miss_q  <= lookup_valid_i && !(|lk_match);
      frame_q <= lookup_valid_i ? lk_frame : '0;
    end
  end

  assign hit_o   = hit_q;
  assign miss_o  = miss_q;
  assign frame_o = frame_q;

  AST_HIT_MISS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && miss_o)); // R2
  AST_LOOKUP_ANSWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_valid_i |=> (hit_o || miss_o)); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_valid_i |=> (!hit_o && !miss_o)); // R2
  AST_NO_DUP_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match)); // R5
  AST_MISS_ZERO_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> frame_o == '0); // R2
endmodule

// File: tb/asid_tlb_bench.sv
module asid_tlb_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lk_v = 1'b0, fl_v = 1'b0, fa_all = 1'b0, fa_asid = 1'b0;
  logic [3:0] lk_a = '0, lk_p = '0, fl_a = '0, fl_p = '0, fl_f = '0, fa_id = '0;
  logic       hit, miss;
  logic [3:0] frame;

  int total = 0;
  int fails = 0;
  logic [5:0] exp_q[$];
  string      tag_q[$];

  logic       mv[8];
  logic [3:0] ma[8], mp[8], mf[8];
  int         mrr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asid_tlb u_asid_tlb (
    .clk_i(clk), .rst_ni(rst_n),
    .lookup_valid_i(lk_v), .lookup_asid_i(lk_a), .lookup_page_i(lk_p),
    .fill_valid_i(fl_v), .fill_asid_i(fl_a), .fill_page_i(fl_p), .fill_frame_i(fl_f),
    .flush_all_i(fa_all), .flush_asid_i(fa_asid), .flush_asid_id_i(fa_id),
    .hit_o(hit), .miss_o(miss), .frame_o(frame)
  );

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s hit/miss/frame actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic lk, input logic [3:0] la, input logic [3:0] lp,
                      input logic fv, input logic [3:0] fa, input logic [3:0] fp,
                      input logic [3:0] ff, input logic all, input logic byid,
                      input logic [3:0] id, input string tag);
    logic       h;
    logic [3:0] fr;
    int         idx;
    @(negedge clk);
    lk_v = lk; lk_a = la; lk_p = lp;
    fl_v = fv; fl_a = fa; fl_p = fp; fl_f = ff;
    fa_all = all; fa_asid = byid; fa_id = id;
    h = 1'b0; fr = 4'd0;
    if (lk) for (int i = 0; i < 8; i++)
      if (mv[i] && ma[i] == la && mp[i] == lp) begin h = 1'b1; fr = mf[i]; end
    exp_q.push_back({lk && h, lk && !h, fr});
    tag_q.push_back(tag);
    if (all) begin
      for (int i = 0; i < 8; i++) mv[i] = 1'b0;
    end else if (byid) begin
      for (int i = 0; i < 8; i++) if (ma[i] == id) mv[i] = 1'b0;
    end else if (fv) begin
      idx = -1;
      for (int i = 0; i < 8; i++) if (mv[i] && ma[i] == fa && mp[i] == fp) idx = i;
      if (idx < 0) for (int i = 7; i >= 0; i--) if (!mv[i]) idx = i;
      if (idx < 0) begin idx = mrr; mrr = (mrr + 1) % 8; end
      mv[idx] = 1'b1; ma[idx] = fa; mp[idx] = fp; mf[idx] = ff;
    end
  endtask

  task automatic lookup(input logic [3:0] a, input logic [3:0] p, input string tag);
    step(1'b1, a, p, 1'b0, 4'd0, 4'd0, 4'd0, 1'b0, 1'b0, 4'd0, tag);
  endtask

  task automatic fill(input logic [3:0] a, input logic [3:0] p, input logic [3:0] f, input string tag);
    step(1'b0, 4'd0, 4'd0, 1'b1, a, p, f, 1'b0, 1'b0, 4'd0, tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 4'd0, 4'd0, 1'b0, 4'd0, 4'd0, 4'd0, 1'b0, 1'b0, 4'd0, tag);
  endtask

  // scoreboard monitor: one item per driven cycle, judged after the edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) check(tag_q.pop_front(), {hit, miss, frame}, exp_q.pop_front());
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mv[i] = 1'b0; ma[i] = '0; mp[i] = '0; mf[i] = '0; end
    repeat (3) @(negedge clk);
    check("R10", {hit, miss, frame}, 6'b0);
    rst_n = 1'b1;
    idle("R2 idle");
    lookup(4'd1, 4'd0, "R2 empty miss");
    // R8: lookup alongside fill of the same translation answers pre-fill
    step(1'b1, 4'd1, 4'd0, 1'b1, 4'd1, 4'd0, 4'd8, 1'b0, 1'b0, 4'd0, "R8");
    lookup(4'd1, 4'd0, "R8 after fill");
    for (int i = 1; i < 8; i++) fill(4'd1, 4'(i), 4'(i + 8), "R4 fill");
    for (int i = 0; i < 8; i++) lookup(4'd1, 4'(i), "R1");
    lookup(4'd2, 4'd3, "R3 foreign asid");
    fill(4'd2, 4'd3, 4'd5, "R4 rr victim 0");
    lookup(4'd1, 4'd0, "R4 evicted");
    lookup(4'd2, 4'd3, "R3 new asid");
    lookup(4'd1, 4'd3, "R3 old asid");
    fill(4'd1, 4'd5, 4'd2, "R5 dup");
    lookup(4'd1, 4'd5, "R5 updated");
    fill(4'd3, 4'd9, 4'd7, "R4 rr victim 1");
    lookup(4'd1, 4'd1, "R5 pointer kept");
    lookup(4'd1, 4'd2, "R4 survivor");
    lookup(4'd3, 4'd9, "R4 victim fill");
    // R9: lookup with an asid flush sees pre-flush entries
    step(1'b1, 4'd1, 4'd2, 1'b0, 4'd0, 4'd0, 4'd0, 1'b0, 1'b1, 4'd1, "R9 pre-flush");
    lookup(4'd1, 4'd2, "R7 cleared");
    lookup(4'd1, 4'd7, "R7 cleared");
    lookup(4'd2, 4'd3, "R7 kept");
    lookup(4'd3, 4'd9, "R7 kept");
    // R9: fill beside a flush is discarded
    step(1'b0, 4'd0, 4'd0, 1'b1, 4'd4, 4'd4, 4'd4, 1'b0, 1'b1, 4'd1, "R9 fill drop");
    lookup(4'd4, 4'd4, "R9 dropped");
    fill(4'd5, 4'd6, 4'd1, "R6 setup");
    lookup(4'd5, 4'd6, "R6 present");
    step(1'b0, 4'd0, 4'd0, 1'b1, 4'd6, 4'd6, 4'd6, 1'b1, 1'b0, 4'd0, "R6 flush");
    lookup(4'd5, 4'd6, "R6 gone");
    lookup(4'd2, 4'd3, "R6 gone");
    lookup(4'd6, 4'd6, "R9 gone");
    fill(4'd7, 4'd1, 4'd3, "R4 refill");
    lookup(4'd7, 4'd1, "R1 refill");
    idle("R2 idle");
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule